// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets held in main memory and streams each packet's payload words to a graphics command port. Each node begins with one 32-bit header word. The header's upper eight bits give how many payload words come right after it. Its lower 24 bits point to the next node. A start pulse carries the address of the first node. The walker then fetches headers and payloads through a synchronous read port with one cycle of latency. Payload words leave on a valid/ready stream.

The walk ends in one of three ways. The first is a next pointer whose bit 23 is set. The second is a revisit caught by a three-entry loop detector. The third is a node-count safety limit. When the walk ends, the block pulses `done` together with two results. One is the number of words consumed, counting headers and payloads. The other is the last next pointer read.

Top module: `chain_walker`

## Requirements
- R1: Every memory read address lies inside a word-aligned 2 MB window. A node address is ANDed with 0x1FFFFC before its header is fetched. Payload addresses are formed as (previous + 4) AND 0x1FFFFC, so a payload that runs past 0x1FFFFC continues at 0x000000.
- R2: Header bits 31:24 hold the payload count and bits 23:0 hold the next pointer. The payload words are read in ascending order starting at header address + 4, and each is presented on the stream in that order. A count of zero streams nothing.
- R3: The walk ends after a node whose next pointer has bit 23 set. This holds for any such value, for example 0x800000, 0x900000 or 0xFFFFFF.
- R4: `done_size` equals 1 plus the sum, over the nodes fetched, of (payload count + 1). `done_next` is the next pointer of the last node fetched.
- R5: The loop detector holds three addresses (last, low and high), all set to 0xFFFFFF at start. Before each fetch, the masked node address is compared with low and high, and a match ends the walk without a fetch. When there is no match, the address replaces low if it is below last and replaces high otherwise, and it then becomes last.
- R6: The node count is checked before each fetch. Once more than NODE_LIMIT nodes have been fetched, the walk ends, so at most NODE_LIMIT+1 headers are read.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. No word is lost or repeated under backpressure.
- R8: `done` is high for exactly one cycle, in the cycle after the terminating condition. `done_size` and `done_next` keep their values until the next `done`.
- R9: A start pulse that arrives while a walk is in progress is ignored.
- R10: After reset, `out_valid`, `done` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| start_addr | input | 24 | Address of the first node |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 24 | Byte address of the read |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Sink accepts the payload word |
| out_data | output | 32 | Payload word |
| done | output | 1 | One-cycle completion pulse |
| done_size | output | 32 | Words consumed, headers included |
| done_next | output | 24 | Last next pointer read |

## Verification
The first chain mixes multi-word, zero-word and single-word nodes and ends on 0x800000. This separates header-field decoding and size accounting from end-marker handling. A start address with stray high bits, and a node near the top of the window, show whether masking and payload wraparound are applied. A two-node cycle, a self-loop and an ascending chain that never ends distinguish the loop detector's low and high entries and the node limit. Random backpressure, and a full stall with a second start pulse, show stream holding and that a busy walker ignores starts.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_CHECK,
    WK_HWAIT,
    WK_HDR,
    WK_PWAIT,
    WK_PAY,
    WK_OUT
  } walk_state_t;
endpackage

// File: rtl/cw_loop_guard.sv
module cw_loop_guard #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              commit,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] FILL = '1;

  logic [ADDR_W-1:0] last_q, low_q, high_q;

  assign hit = (probe == low_q) || (probe == high_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      last_q <= FILL;
      low_q  <= FILL;
      high_q <= FILL;
    end else if (commit) begin
      if (probe < last_q) low_q <= probe;
      else                high_q <= probe;
      last_q <= probe;
    end
  end

  AST_COMMIT_FRESH: assert property (@(posedge clk) disable iff (rst)
    commit |-> !hit); // R5
  AST_COMMIT_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (commit && !clear) |=> (low_q == $past(probe) || high_q == $past(probe))); // R5
endmodule

// File: rtl/cw_node_count.sv
module cw_node_count #(
  parameter int unsigned NODE_LIMIT = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic over
);
  localparam int unsigned CW = $clog2(NODE_LIMIT + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(NODE_LIMIT);

  logic [CW-1:0] cnt_q;

  assign over = cnt_q > LIM;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  AST_NO_FETCH_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    inc |-> !over); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM + 1'b1); // R6
endmodule

// File: rtl/cw_stream_reg.sv
module cw_stream_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              taken
);
  assign taken = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (taken) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid); // R7
endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned SIZE_W     = 32,
  parameter int unsigned NODE_LIMIT = 2000000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 24'h1FFFFC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  output logic                    mem_rd_en,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic [ADDR_W+CNT_W-1:0] mem_rd_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W+CNT_W-1:0] out_data,
  output logic                    done,
  output logic [SIZE_W-1:0]       done_size,
  output logic [ADDR_W-1:0]       done_next
);
  import cw_pkg::*;

  localparam int unsigned DATA_W = ADDR_W + CNT_W;
  localparam int unsigned END_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  walk_state_t st_q;
  logic [ADDR_W-1:0] cur_q, node_q, pay_q, nxt_q;
  logic [CNT_W-1:0]  remain_q;
  logic [SIZE_W-1:0] size_q;

  logic [ADDR_W-1:0] probe, pay_first, pay_step, hdr_nxt;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [SIZE_W-1:0] size_hdr;
  logic hit, over, taken, check_go, guard_clear, load;

  always_comb begin
    probe       = cur_q & WIN_MASK;
    hdr_cnt     = mem_rd_data[DATA_W-1 -: CNT_W];
    hdr_nxt     = mem_rd_data[ADDR_W-1:0];
    size_hdr    = size_q + SIZE_W'(hdr_cnt) + SIZE_W'(1);
    pay_first   = (node_q + STEP) & WIN_MASK;
    pay_step    = (pay_q + STEP) & WIN_MASK;
    check_go    = (st_q == WK_CHECK) && !over && !hit;
    guard_clear = (st_q == WK_IDLE) && start;
    load        = (st_q == WK_PAY);
  end

  cw_loop_guard #(.ADDR_W(ADDR_W)) guard_i (
    .clk(clk), .rst(rst), .clear(guard_clear), .commit(check_go),
    .probe(probe), .hit(hit)
  );

  cw_node_count #(.NODE_LIMIT(NODE_LIMIT)) count_i (
    .clk(clk), .rst(rst), .clear(guard_clear), .inc(check_go), .over(over)
  );

  cw_stream_reg #(.DATA_W(DATA_W)) stream_i (
    .clk(clk), .rst(rst), .load(load), .load_data(mem_rd_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .taken(taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= WK_IDLE;
      cur_q       <= '0;
      node_q      <= '0;
      pay_q       <= '0;
      nxt_q       <= '0;
      remain_q    <= '0;
      size_q      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      done_size   <= '0;
      done_next   <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      case (st_q)
        WK_IDLE: begin
          if (start) begin
            cur_q  <= start_addr;
            nxt_q  <= start_addr;
            size_q <= SIZE_W'(1);
            st_q   <= WK_CHECK;
          end
        end
        WK_CHECK: begin
          if (over || hit) begin
            done      <= 1'b1;
            done_size <= size_q;
            done_next <= nxt_q;
            st_q      <= WK_IDLE;
          end else begin
            node_q      <= probe;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= probe;
            st_q        <= WK_HWAIT;
          end
        end
        WK_HWAIT: st_q <= WK_HDR;
        WK_HDR: begin
          size_q   <= size_hdr;
          nxt_q    <= hdr_nxt;
          cur_q    <= hdr_nxt;
          remain_q <= hdr_cnt;
          if (hdr_cnt == '0) begin
            if (hdr_nxt[END_BIT]) begin
              done      <= 1'b1;
              done_size <= size_hdr;
              done_next <= hdr_nxt;
              st_q      <= WK_IDLE;
            end else begin
              st_q <= WK_CHECK;
            end
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= pay_first;
            pay_q       <= pay_first;
            st_q        <= WK_PWAIT;
          end
        end
        WK_PWAIT: st_q <= WK_PAY;
        WK_PAY:   st_q <= WK_OUT;
        WK_OUT: begin
          if (taken) begin
            if (remain_q == CNT_W'(1)) begin
              if (nxt_q[END_BIT]) begin
                done      <= 1'b1;
                done_size <= size_q;
                done_next <= nxt_q;
                st_q      <= WK_IDLE;
              end else begin
                st_q <= WK_CHECK;
              end
            end else begin
              remain_q    <= remain_q - 1'b1;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= pay_step;
              pay_q       <= pay_step;
              st_q        <= WK_PWAIT;
            end
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ((mem_rd_addr & ~WIN_MASK) == '0)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(done_size) && $stable(done_next))); // R8
  AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_size != '0)); // R4
endmodule

// File: tb/chain_walker_tb_top.sv
module chain_walker_tb_top;
  localparam int unsigned LIM = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        done;
  logic [31:0] done_size;
  logic [23:0] done_next;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] exp_q [$];
  bit   bp_on = 1'b0;
  bit   stall = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  bit   hold_pend = 1'b0;
  logic [31:0] hold_data = '0;

  always #10 clk = ~clk;

  chain_walker #(.NODE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .done_size(done_size), .done_next(done_next)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (mem.exists(int'(mem_rd_addr))) mem_rd_data <= mem[int'(mem_rd_addr)];
      else mem_rd_data <= 32'hDEAD_0000;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: drives ready, pops expected payload on each handshake
  always @(negedge clk) begin
    if (!rst) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? lfsr[0] : !stall;
      if (hold_pend)
        chk(out_valid && out_data == hold_data, "R7 hold", {31'd0, out_valid, out_data},
            {32'd1, hold_data});
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", 64'(out_data), 64'd0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R2 payload", 64'(out_data), 64'(e));
        end
      end
    end
  end

  task automatic hdr(input int unsigned a, input logic [7:0] c, input logic [23:0] n);
    mem[a] = {c, n};
  endtask

  task automatic pay(input int unsigned a, input logic [31:0] d);
    mem[a] = d;
    exp_q.push_back(d);
  endtask

  task automatic kick(input logic [23:0] a);
    @(negedge clk);
    start = 1'b1;
    start_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, input logic [31:0] esz, input logic [23:0] enx);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {req, " done seen"}, 64'(done), 64'd1);
    chk(done_size == esz, {req, " R4 size"}, 64'(done_size), 64'(esz));
    chk(done_next == enx, {req, " R4 next"}, 64'(done_next), 64'(enx));
    chk(exp_q.size() == 0, {req, " R2 words left"}, 64'(exp_q.size()), 64'd0);
    @(negedge clk);
    chk(!done, "R8 single pulse", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk(done_size == esz && done_next == enx, "R8 result held", 64'(done_size), 64'(esz));
    mem.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && !mem_rd_en, "R10 reset outputs",
        {61'd0, out_valid, done, mem_rd_en}, 64'd0);
    rst = 1'b0;

    // mixed chain ending on 0x800000
    hdr(32'h1000, 8'd2, 24'h001010); pay(32'h1004, 32'hA1A1_0001); pay(32'h1008, 32'hA1A1_0002);
    hdr(32'h1010, 8'd0, 24'h002000);
    hdr(32'h2000, 8'd1, 24'h800000); pay(32'h2004, 32'hB1B1_0001);
    kick(24'h001000);
    wait_done("R3 chain", 32'd7, 24'h800000);

    // stray high bits in start address, all-ones end marker, backpressure
    bp_on = 1'b1;
    hdr(32'h1E3000, 8'd3, 24'hFFFFFF);
    pay(32'h1E3004, 32'hC0C0_0001); pay(32'h1E3008, 32'hC0C0_0002); pay(32'h1E300C, 32'hC0C0_0003);
    kick(24'h3E3003);
    wait_done("R1 mask", 32'd5, 24'hFFFFFF);

    // payload wraps at top of window
    hdr(32'h1FFFF8, 8'd2, 24'h900000);
    pay(32'h1FFFFC, 32'hD0D0_0001); pay(32'h000000, 32'hD0D0_0002);
    kick(24'h1FFFF8);
    wait_done("R1 wrap", 32'd4, 24'h900000);
    bp_on = 1'b0;

    // two-node cycle: low entry catches the revisit
    hdr(32'h100, 8'd1, 24'h000200); pay(32'h104, 32'hE0E0_0001);
    hdr(32'h200, 8'd0, 24'h000100);
    kick(24'h000100);
    wait_done("R5 cycle", 32'd4, 24'h000100);

    // self loop
    hdr(32'h300, 8'd0, 24'h000300);
    kick(24'h000300);
    wait_done("R5 self", 32'd2, 24'h000300);

    // descending then ascending then revisit of low entry
    hdr(32'h500, 8'd0, 24'h000400);
    hdr(32'h400, 8'd0, 24'h000600);
    hdr(32'h600, 8'd0, 24'h000400);
    kick(24'h000500);
    wait_done("R5 low/high", 32'd4, 24'h000400);

    // endless ascending chain: node limit LIM=5 stops after 6 headers
    for (int i = 0; i < 10; i++) hdr(32'h4000 + 16 * i, 8'd0, 24'(32'h4010 + 16 * i));
    kick(24'h004000);
    wait_done("R6 limit", 32'd7, 24'h004060);

    // start while busy is ignored
    stall = 1'b1;
    hdr(32'h6000, 8'd2, 24'h800000); pay(32'h6004, 32'hF0F0_0001); pay(32'h6008, 32'hF0F0_0002);
    mem[32'h5000] = {8'd1, 24'h800000};
    mem[32'h5004] = 32'hBAD0_0001;
    kick(24'h006000);
    repeat (10) @(negedge clk);
    kick(24'h005000);
    repeat (3) @(negedge clk);
    stall = 1'b0;
    wait_done("R9 busy start", 32'd4, 24'h800000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule